// File: doc/BRIEF.md
# Serial Link Bring-Up Controller

This block sequences a serial receiver from power-up to payload delivery, without needing a reference clock. It waits in a low-power state until the line carries a signal and the clock recovery unit reports lock. When the handshaking feature is on, it then waits for the peer transmitter's training pattern to appear. It counts a fixed number of training-pattern matches, spends one cycle on word-boundary alignment, and then enters normal operation. When the feature is off, it moves straight to normal operation once lock is reported.

If the link degrades, the controller falls back. Losing the signal returns it to idle. Losing lock while the signal is still present returns it to link detect, or to idle if it had not yet got past link detect. A watchdog counter aborts a stalled detect or acquisition phase. Every fallback raises a stretched link-break pulse, which the back-channel logic uses to tell the transmitter to restart.

Top module: `link_bringup_ctrl`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, link_state is 0 (idle), low_power is 1, align_done is 0 and link_break is 0.
- R2: The state codes are idle=0, detect=1, acquire=2, align=3 and normal=4, and forward progress only ever moves to the next code. The controller stays in idle until sig_det and cdr_lock are both high in the same cycle.
- R3: With remote_en high, idle moves to detect. Detect moves to acquire on the first train_match strobe, and that strobe is not counted toward training.
- R4: In acquire, the TRAIN_LEN-th train_match strobe moves the controller to align. Align lasts exactly one cycle and then moves to normal. align_done is high exactly in normal.
- R5: With remote_en low, idle moves directly to normal once sig_det and cdr_lock are high. remote_en is sampled only in idle and has no effect in any other state.
- R6: In any non-idle state, a low sig_det returns the controller to idle on the next edge. This takes priority over every other input.
- R7: A low cdr_lock with sig_det still high returns acquire, align and handshaked normal to detect. It returns detect, and a normal state reached without handshaking, to idle.
- R8: If the controller spends TIMEOUT consecutive cycles in detect or acquire with no train_match strobe, it aborts to idle. Each strobe restarts that window.
- R9: Every fallback (R6, R7, R8) drives link_break high for BREAK_LEN cycles, starting in the cycle after the transition. A new fallback restarts the full length.
- R10: low_power is high exactly when the controller is in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| remote_en | input | 1 | Enables the handshaked bring-up sequence |
| sig_det | input | 1 | Line signal present |
| cdr_lock | input | 1 | Clock recovery lock indication |
| train_match | input | 1 | One-cycle strobe per recognised training pattern |
| link_state | output | 3 | Current state code |
| low_power | output | 1 | Receiver may sit in low-power mode |
| align_done | output | 1 | Alignment finished; payload may pass |
| link_break | output | 1 | Stretched pulse requesting a link restart |

## Verification
The embedded properties check several behaviours on every cycle:
- forward moves never skip a state, except the bypass jump from idle to normal;
- signal loss always lands in idle;
- entry into detect always follows lock;
- every backward move coincides with link_break;
- no break pulse is shorter than four cycles;
- the timeout counter never passes its limit.

Only the bench scenarios show the rest:
- the exact number of strobes acquisition consumes;
- which fallback target a lock loss selects in each state;
- that remote_en is ignored after idle;
- the precise cycle on which the timeout fires, and that a strobe restarts the window;
- where a break pulse ends when a second fallback restarts it.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
    typedef enum logic [2:0] {
        LBC_IDLE    = 3'd0,
        LBC_DETECT  = 3'd1,
        LBC_ACQUIRE = 3'd2,
        LBC_ALIGN   = 3'd3,
        LBC_NORMAL  = 3'd4
    } lbc_state_e;
endpackage

// File: rtl/lbc_watchdog.sv
module lbc_watchdog #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic expired
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run || clear) cnt_d = '0;
        else               cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q == CW'(LIMIT - 1));

    // R8: the state machine must leave or clear before the count passes the limit
    p_timer_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> (cnt_q == '0));
endmodule

// File: rtl/lbc_break_stretch.sv
module lbc_break_stretch #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic pulse
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (trigger)           cnt_d = CW'(LEN);
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        else                   cnt_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign pulse = (cnt_q != '0);

    generate
        if (LEN >= 4) begin : g_min_len
            // R9: a pulse never ends before four cycles have elapsed
            p_break_min_r9: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(pulse) |-> ($past(pulse, 2) && $past(pulse, 3) && $past(pulse, 4)));
        end
    endgenerate
endmodule

// File: rtl/link_bringup_ctrl.sv
module link_bringup_ctrl
    import lbc_pkg::*;
#(
    parameter int TIMEOUT   = 1024,
    parameter int TRAIN_LEN = 4,
    parameter int BREAK_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       remote_en,
    input  logic       sig_det,
    input  logic       cdr_lock,
    input  logic       train_match,
    output logic [2:0] link_state,
    output logic       low_power,
    output logic       align_done,
    output logic       link_break
);
    localparam int TW = (TRAIN_LEN > 2) ? $clog2(TRAIN_LEN) : 1;

    typedef struct packed {
        lbc_state_e     st;
        logic           bypass;
        logic [TW-1:0]  tcnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic fallback_d;
    logic expired;
    logic tmr_run, tmr_clear;

    always_comb begin
        ctl_d      = ctl_q;
        fallback_d = 1'b0;
        if (ctl_q.st == LBC_IDLE) begin
            if (sig_det && cdr_lock) begin
                if (remote_en) begin
                    ctl_d.st = LBC_DETECT;
                end else begin
                    ctl_d.st     = LBC_NORMAL;
                    ctl_d.bypass = 1'b1;
                end
            end
        end else if (!sig_det) begin
            ctl_d.st   = LBC_IDLE;
            fallback_d = 1'b1;
        end else if (!cdr_lock) begin
            fallback_d = 1'b1;
            ctl_d.st   = (ctl_q.st == LBC_DETECT || ctl_q.bypass) ? LBC_IDLE : LBC_DETECT;
        end else begin
            case (ctl_q.st)
                LBC_DETECT: begin
                    if (train_match) begin
                        ctl_d.st   = LBC_ACQUIRE;
                        ctl_d.tcnt = '0;
                    end else if (expired) begin
                        ctl_d.st   = LBC_IDLE;
                        fallback_d = 1'b1;
                    end
                end
                LBC_ACQUIRE: begin
                    if (train_match) begin
                        if (ctl_q.tcnt == TW'(TRAIN_LEN - 1)) ctl_d.st = LBC_ALIGN;
                        else                                  ctl_d.tcnt = ctl_q.tcnt + 1'b1;
                    end else if (expired) begin
                        ctl_d.st   = LBC_IDLE;
                        fallback_d = 1'b1;
                    end
                end
                LBC_ALIGN: ctl_d.st = LBC_NORMAL;
                default: ;
            endcase
        end
        if (ctl_d.st == LBC_IDLE || ctl_d.st == LBC_DETECT) ctl_d.bypass = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st     <= LBC_IDLE;
            ctl_q.bypass <= 1'b0;
            ctl_q.tcnt   <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign tmr_run   = (ctl_q.st == LBC_DETECT) || (ctl_q.st == LBC_ACQUIRE);
    assign tmr_clear = (ctl_d.st != ctl_q.st) || train_match;

    lbc_watchdog #(.LIMIT(TIMEOUT)) u_watchdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .clear   (tmr_clear),
        .expired (expired)
    );

    lbc_break_stretch #(.LEN(BREAK_LEN)) u_break (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (fallback_d),
        .pulse   (link_break)
    );

    assign link_state = ctl_q.st;
    assign low_power  = (ctl_q.st == LBC_IDLE);
    assign align_done = (ctl_q.st == LBC_NORMAL);

    // R2: forward moves step one code at a time, apart from the bypass jump (R5)
    p_forward_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_d.st > ctl_q.st) |-> ((ctl_d.st == ctl_q.st + 3'd1) ||
            (ctl_q.st == LBC_IDLE && ctl_d.st == LBC_NORMAL && !remote_en)));

    // R3: detect is entered from idle only with lock and signal present
    p_detect_needs_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == LBC_IDLE && !(sig_det && cdr_lock)) |=> (ctl_q.st == LBC_IDLE));

    // R6: signal loss always lands in idle
    p_sig_loss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sig_det) |=> (link_state == 3'd0));

    // R9: every backward move is accompanied by the break pulse
    p_break_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_d.st < ctl_q.st) |=> link_break);
endmodule

// File: tb/link_bringup_ctrl_bench.sv
module link_bringup_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 39;

    // {sig_det, cdr_lock, remote_en, train_match, expected state[2:0], expected break}
    localparam logic [7:0] VEC [0:NVEC-1] = '{
        8'b0010_000_0, 8'b1010_000_0, 8'b1110_001_0, 8'b1110_001_0,
        8'b1111_010_0, 8'b1111_010_0, 8'b1110_010_0, 8'b1111_010_0,
        8'b1111_010_0, 8'b1111_011_0, 8'b1110_100_0, 8'b1111_100_0,
        8'b1010_001_1, 8'b1010_000_1, 8'b0010_000_1, 8'b0010_000_1,
        8'b0010_000_1, 8'b0010_000_0, 8'b1100_100_0, 8'b1000_000_1,
        8'b0010_000_1, 8'b0010_000_1, 8'b0010_000_1, 8'b0010_000_0,
        8'b1110_001_0, 8'b1111_010_0, 8'b0111_000_1, 8'b0010_000_1,
        8'b0010_000_1, 8'b0010_000_1, 8'b0010_000_0, 8'b1110_001_0,
        8'b1100_001_0, 8'b1101_010_0, 8'b1111_010_0, 8'b1111_010_0,
        8'b1111_010_0, 8'b1111_011_0, 8'b1010_001_1
    };

    logic clk = 1'b0;
    logic rst_n, remote_en, sig_det, cdr_lock, train_match;
    logic [2:0] link_state;
    logic low_power, align_done, link_break;
    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_bringup_ctrl u_link_bringup_ctrl (
        .clk(clk), .rst_n(rst_n), .remote_en(remote_en), .sig_det(sig_det),
        .cdr_lock(cdr_lock), .train_match(train_match), .link_state(link_state),
        .low_power(low_power), .align_done(align_done), .link_break(link_break)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_state(input int exp_st, input string req);
        check(link_state == 3'(exp_st), req, int'(link_state), exp_st);
        check(low_power == (exp_st == 0), "R10 low_power", int'(low_power), int'(exp_st == 0));
        check(align_done == (exp_st == 4), "R4 align_done", int'(align_done), int'(exp_st == 4));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sig_det = 1'b0; cdr_lock = 1'b0; remote_en = 1'b1; train_match = 1'b0;
        repeat (3) @(negedge clk);
        check_state(0, "R1 state in reset");
        check(link_break == 1'b0, "R1 break in reset", int'(link_break), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired: actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        check_state(0, "R1 state after release");
        check(link_break == 1'b0, "R1 break after release", int'(link_break), 0);

        // vector walk: R2 R3 R4 R5 R6 R7 R9
        for (int i = 0; i < NVEC; i++) begin
            {sig_det, cdr_lock, remote_en, train_match} = VEC[i][7:4];
            @(negedge clk);
            check_state(int'(VEC[i][3:1]), $sformatf("R2 R3 R4 R5 R6 R7 state vec %0d", i));
            check(link_break == VEC[i][0], $sformatf("R9 break vec %0d", i),
                  int'(link_break), int'(VEC[i][0]));
        end

        // R8: timeout in detect after exactly TIMEOUT cycles
        do_reset();
        sig_det = 1'b1; cdr_lock = 1'b1; remote_en = 1'b1; train_match = 1'b0;
        @(negedge clk);
        check_state(1, "R8 entered detect");
        repeat (1023) @(negedge clk);
        check_state(1, "R8 detect before timeout");
        @(negedge clk);
        check_state(0, "R8 detect timed out");
        check(link_break == 1'b1, "R9 break on timeout", int'(link_break), 1);

        // R8: a strobe in acquire restarts the window
        @(negedge clk);
        check_state(1, "R8 re-entered detect");
        train_match = 1'b1;
        @(negedge clk);
        train_match = 1'b0;
        check_state(2, "R8 entered acquire");
        repeat (1000) @(negedge clk);
        train_match = 1'b1;
        @(negedge clk);
        train_match = 1'b0;
        repeat (1000) @(negedge clk);
        check_state(2, "R8 strobe restarted window");
        repeat (23) @(negedge clk);
        check_state(2, "R8 acquire last cycle");
        @(negedge clk);
        check_state(0, "R8 acquire timed out");

        // R1: reset from an active link
        @(negedge clk);
        train_match = 1'b1;
        @(negedge clk);
        train_match = 1'b0;
        do_reset();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule